// File: doc/BRIEF.md
# Segmented Parallel Prefix Scan

This block takes a whole vector of N unsigned W-bit elements and returns the inclusive running combination of it: output element i is the combination of every input element from the start of its segment up to and including element i. The combining operator is chosen per vector from four associative functions: wrapping sum, unsigned minimum, unsigned maximum and bitwise OR. A companion vector of head flags, one per element, splits the input into independent runs. No value crosses the start of a run, so many variable-length sequences can be scanned in one pass.

The work is spread over log2(N) pipeline stages. Stage k combines each element with the element 2^k positions to its left, and propagates the head flags with the same stride. Each stage ends in a register, so every stage works only on the finished results of the one before it. Input and output are full vectors, each with a valid/ready handshake. A new vector can be accepted on every cycle while the output side keeps up.

Top module: `seg_prefix_scan`

## Requirements
- R1: While reset is asserted and after it is released with no input, out_valid is 0 and in_ready is 1.
- R2: With in_op = 0, output element i is the sum of the elements of its segment up to i, taken modulo 2^W.
- R3: With in_op = 1, output element i is the unsigned minimum of the elements of its segment up to i.
- R4: With in_op = 2, output element i is the unsigned maximum of the elements of its segment up to i.
- R5: With in_op = 3, output element i is the bitwise OR of the elements of its segment up to i.
- R6: A head bit in_head[i] = 1 starts a new segment at element i, so output i and all outputs to its right up to the next head ignore every element left of i. Element 0 always starts a segment. An element whose head bit is set comes out unchanged.
- R7: A vector accepted in cycle c (in_valid and in_ready both high) appears on out_valid in cycle c + log2(N) if the output is not stalled. Back-to-back vectors are accepted one per cycle while out_ready stays high.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change in the next cycle.
- R9: Vectors leave in the order they were accepted, with none lost or repeated. With out_ready held low, exactly log2(N) vectors are accepted and in_ready then stays 0.
- R10: Element i occupies bits [i*W +: W] of in_data and out_data, and its head flag is bit i of in_head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Block can take the input vector this cycle |
| in_op | input | 2 | Operator: 0 sum, 1 min, 2 max, 3 OR |
| in_data | input | N*W | Input elements, element i at [i*W +: W] |
| in_head | input | N | Segment start flags, bit i for element i |
| out_valid | output | 1 | Result vector present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | N*W | Scan results, element i at [i*W +: W] |

## Verification
The hardest condition to reach from the ports is a partly filled pipeline that is stalled while new vectors keep arriving. In that state the stages hold bubbles between valid entries, and those bubbles must close without dropping or reordering a vector. The stimulus gets there by driving in_valid and out_ready from independent random draws over several thousand cycles. It also holds out_ready low on a full pipeline until in_ready drops. Random head densities, including runs of adjacent heads and heads at element 0, are mixed with small value ranges. This makes ties in min and max and long carry chains in the sum occur often.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

  typedef enum logic [1:0] {
    SCAN_ADD = 2'd0,
    SCAN_MIN = 2'd1,
    SCAN_MAX = 2'd2,
    SCAN_OR  = 2'd3
  } scan_op_e;

endpackage

// File: rtl/scan_op.sv
module scan_op
  import seg_scan_pkg::*;
#(
  parameter int W = 16
) (
  input  scan_op_e       op,
  input  logic [W-1:0]   lhs,
  input  logic [W-1:0]   rhs,
  output logic [W-1:0]   res
);

  always_comb begin
    unique case (op)
      SCAN_ADD: res = lhs + rhs;
      SCAN_MIN: res = (lhs < rhs) ? lhs : rhs;
      SCAN_MAX: res = (lhs > rhs) ? lhs : rhs;
      default:  res = lhs | rhs;
    endcase
  end

endmodule

// File: rtl/scan_stage.sv
module scan_stage
  import seg_scan_pkg::*;
#(
  parameter int N    = 16,
  parameter int W    = 16,
  parameter int DIST = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           up_valid,
  output logic           up_ready,
  input  scan_op_e       up_op,
  input  logic [N*W-1:0] up_data,
  input  logic [N-1:0]   up_head,
  output logic           dn_valid,
  input  logic           dn_ready,
  output scan_op_e       dn_op,
  output logic [N*W-1:0] dn_data,
  output logic [N-1:0]   dn_head
);

  logic [N*W-1:0] comb_data;
  logic [N-1:0]   comb_head;

  logic           vld_q, vld_d;
  logic           load_en, cap_en;
  scan_op_e       op_q;
  logic [N*W-1:0] data_q;
  logic [N-1:0]   head_q;

  // combine network: element i looks DIST places to the left
  for (genvar i = 0; i < N; i++) begin : g_elem
    if (i >= DIST) begin : g_comb
      logic [W-1:0] joined;
      scan_op #(.W(W)) u_op (
        .op  (up_op),
        .lhs (up_data[(i-DIST)*W +: W]),
        .rhs (up_data[i*W +: W]),
        .res (joined)
      );
      assign comb_data[i*W +: W] = up_head[i] ? up_data[i*W +: W] : joined;
      assign comb_head[i]        = up_head[i] | up_head[i-DIST];
    end else begin : g_pass
      assign comb_data[i*W +: W] = up_data[i*W +: W];
      assign comb_head[i]        = up_head[i];
    end
  end

  // next-state
  always_comb begin
    load_en = !vld_q || dn_ready;
    cap_en  = load_en && up_valid;
    vld_d   = load_en ? up_valid : vld_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      op_q   <= up_op;
      data_q <= comb_data;
      head_q <= comb_head;
    end
  end

  assign up_ready = load_en;
  assign dn_valid = vld_q;
  assign dn_op    = op_q;
  assign dn_data  = data_q;
  assign dn_head  = head_q;

  // R8
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !dn_ready) |=> (vld_q && $stable(data_q)));

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R6
    head_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_ready && up_head[i]) |=>
        (data_q[i*W +: W] == $past(up_data[i*W +: W])));
    // R4
    max_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_ready && up_op == SCAN_MAX) |=>
        (data_q[i*W +: W] >= $past(up_data[i*W +: W])));
    // R3
    min_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_ready && up_op == SCAN_MIN) |=>
        (data_q[i*W +: W] <= $past(up_data[i*W +: W])));
    // R5
    or_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_ready && up_op == SCAN_OR) |=>
        ((data_q[i*W +: W] & $past(up_data[i*W +: W])) == $past(up_data[i*W +: W])));
  end

endmodule

// File: rtl/seg_prefix_scan.sv
module seg_prefix_scan
  import seg_scan_pkg::*;
#(
  parameter int N = 16,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [1:0]     in_op,
  input  logic [N*W-1:0] in_data,
  input  logic [N-1:0]   in_head,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [N*W-1:0] out_data
);

  localparam int STAGES = $clog2(N);

  logic           st_valid [0:STAGES];
  logic           st_ready [0:STAGES];
  scan_op_e       st_op    [0:STAGES];
  logic [N*W-1:0] st_data  [0:STAGES];
  logic [N-1:0]   st_head  [0:STAGES];

  assign st_valid[0]      = in_valid;
  assign st_op[0]         = scan_op_e'(in_op);
  assign st_data[0]       = in_data;
  assign st_head[0]       = in_head;
  assign st_ready[STAGES] = out_ready;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    scan_stage #(.N(N), .W(W), .DIST(1 << k)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_valid (st_valid[k]),
      .up_ready (st_ready[k]),
      .up_op    (st_op[k]),
      .up_data  (st_data[k]),
      .up_head  (st_head[k]),
      .dn_valid (st_valid[k+1]),
      .dn_ready (st_ready[k+1]),
      .dn_op    (st_op[k+1]),
      .dn_data  (st_data[k+1]),
      .dn_head  (st_head[k+1])
    );
  end

  assign in_ready  = st_ready[0];
  assign out_valid = st_valid[STAGES];
  assign out_data  = st_data[STAGES];

  // R9
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R1
  rst_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && in_ready));

endmodule

// File: tb/seg_prefix_scan_tb.sv
module seg_prefix_scan_tb;

  localparam int N = 16;
  localparam int W = 16;
  localparam int S = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic           in_ready;
  logic [1:0]     in_op;
  logic [N*W-1:0] in_data;
  logic [N-1:0]   in_head;
  logic           out_valid;
  logic           out_ready;
  logic [N*W-1:0] out_data;

  always #4 clk = ~clk;

  seg_prefix_scan #(.N(N), .W(W)) u_dut (
    .clk, .rst_n, .in_valid, .in_ready, .in_op, .in_data, .in_head,
    .out_valid, .out_ready, .out_data
  );

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  logic [N*W-1:0] exp_q[$];
  logic [1:0]     opq[$];
  bit             hold_pending = 0;
  logic [N*W-1:0] hold_data;
  bit             last_ov;

  task automatic check(input bit ok, input string req,
                       input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [1:0] op);
    case (op)
      2'd0:    return "R2 R6 R10";
      2'd1:    return "R3 R6 R10";
      2'd2:    return "R4 R6 R10";
      default: return "R5 R6 R10";
    endcase
  endfunction

  function automatic logic [W-1:0] ref_op(input logic [1:0] op,
                                          input logic [W-1:0] a, input logic [W-1:0] b);
    case (op)
      2'd0:    return a + b;
      2'd1:    return (a < b) ? a : b;
      2'd2:    return (a > b) ? a : b;
      default: return a | b;
    endcase
  endfunction

  function automatic logic [N*W-1:0] ref_scan(input logic [1:0] op,
      input logic [N*W-1:0] d, input logic [N-1:0] h);
    logic [N*W-1:0] r;
    logic [W-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      if (i == 0 || h[i]) acc = d[i*W +: W];
      else                acc = ref_op(op, acc, d[i*W +: W]);
      r[i*W +: W] = acc;
    end
    return r;
  endfunction

  task automatic step(input logic iv, input logic [1:0] op, input logic [N*W-1:0] d,
                      input logic [N-1:0] h, input logic ordy, output bit acc);
    @(negedge clk);
    in_valid = iv; in_op = op; in_data = d; in_head = h; out_ready = ordy;
    #1;
    acc = iv && in_ready;
    last_ov = out_valid;
    if (hold_pending)
      check(out_valid && out_data == hold_data, "R8", out_data, hold_data);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(0, "R9 spurious output", out_data, '0);
      else begin
        logic [N*W-1:0] e;
        logic [1:0] o;
        e = exp_q.pop_front();
        o = opq.pop_front();
        check(out_data == e, op_tag(o), out_data, e);
      end
    end
    hold_pending = out_valid && !out_ready;
    hold_data = out_data;
    if (acc) begin
      exp_q.push_back(ref_scan(op, d, h));
      opq.push_back(op);
    end
  endtask

  task automatic idle(input int n);
    bit a;
    for (int k = 0; k < n; k++) step(0, 2'd0, '0, '0, 1, a);
  endtask

  task automatic send(input logic [1:0] op, input logic [N*W-1:0] d, input logic [N-1:0] h);
    bit a;
    a = 0;
    for (int k = 0; k < 20 && !a; k++) step(1, op, d, h, 1, a);
  endtask

  function automatic logic [N*W-1:0] rnd_vec(input int range_bits);
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++)
      v[i*W +: W] = W'($urandom) & W'((32'd1 << range_bits) - 1);
    return v;
  endfunction

  initial begin
    logic [N*W-1:0] v;
    bit a;
    int lat, cnt;
    rst_n = 0; in_valid = 0; in_op = 0; in_data = '0; in_head = '0; out_ready = 1;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!out_valid && in_ready, "R1 in reset", {out_valid, in_ready}, 2'b01);
    rst_n = 1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 after release", {out_valid, in_ready}, 2'b01);

    // R2: ascending 1..N summed, no heads
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(i + 1);
    // R7 latency from acceptance to out_valid
    step(1, 2'd0, v, '0, 1, a);
    check(a, "R7 accept", a, 1);
    lat = 0;
    for (int k = 1; k <= 8; k++) begin
      step(0, 2'd0, '0, '0, 1, a);
      if (lat == 0 && last_ov) lat = k;
    end
    check(lat == S, "R7 latency", lat, S);

    // R2 wrap modulo 2^W
    send(2'd0, {N{16'hFFFF}}, '0);
    send(2'd0, {N{16'h8001}}, 16'h0101);
    // R3 / R4 / R5 / R6 directed segmented cases
    for (int i = 0; i < N; i++) v[i*W +: W] = W'((i * 37 + 11) % 97);
    send(2'd1, v, 16'h1111);
    send(2'd2, v, 16'h8421);
    send(2'd3, v, 16'hFFFF);
    send(2'd0, v, 16'h0001);
    send(2'd3, {N{16'h0000}} | 256'h1, 16'h0000);
    idle(8);

    // R7 throughput: back-to-back
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      step(1, 2'(k % 4), rnd_vec(16), 16'($urandom), 1, a);
      if (a) cnt++;
    end
    check(cnt == 20, "R7 throughput", cnt, 20);
    idle(8);

    // R9 fill with output stalled
    cnt = 0;
    for (int k = 0; k < 10; k++) begin
      step(1, 2'd2, rnd_vec(4), 16'($urandom), 0, a);
      if (a) cnt++;
    end
    check(cnt == S, "R9 fill count", cnt, S);
    check(!in_ready, "R9 in_ready low when full", in_ready, 0);
    idle(10);

    // random stream with random stalls
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] h;
      h = ($urandom % 3 == 0) ? 16'($urandom) : 16'($urandom & $urandom & $urandom);
      step(($urandom % 4) != 0, 2'($urandom), rnd_vec(($urandom % 2) ? 3 : 16), h,
           ($urandom % 3) != 0, a);
    end
    idle(12);
    check(exp_q.size() == 0, "R9 all delivered", exp_q.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule